// File: doc/BRIEF.md
# Soft-Start Sequencer with Overcurrent Fault Latch

This block governs start-up and overcurrent recovery for a digital PWM stage. It keeps a soft-start level as an up/down counter. The PWM generator may never be granted more duty than that level, so after power-up or a fault the usable duty rises slowly from zero. A supply monitor with separate turn-on and turn-off thresholds holds everything off while the supply is too low. The monitor overrides every other condition, and when it trips it also clears any pending fault.

An overcurrent flag sets a fault latch. While the latch is set, the outputs are held off and the soft-start level is swept fully down to a low restart threshold before charging starts again. A fault that arrives while the level is still climbing does not cut the climb short. The level finishes charging to full first and only then discharges. This bounds the fault repetition rate to at most one per soft-start period. Charging climbs in small steps and discharge falls in large steps, in a fixed ratio.

Top module: `softstart_fault_seq`

## Requirements
- R1: After reset, `out_en` is 0, `ss_level` is 0 and `duty_lim` is 0.
- R2: In the charging phase, `ss_level` rises by `UP_STEP` (default 1) each cycle and stops at `FULL_LVL` (default 720). On the cycle it reaches the full level, the block enters the run phase. `out_en` is 1 throughout charging.
- R3: In the run phase, `ss_level` stays at `FULL_LVL` and `out_en` is 1. If `ovc` is sampled high, `out_en` is 0 from the next cycle and discharge begins.
- R4: If `ovc` is sampled high during charging, `out_en` is 0 from the next cycle. `ss_level` keeps rising by `UP_STEP` per cycle until it reaches `FULL_LVL`, and discharge starts on the following cycle.
- R5: During discharge, `ss_level` falls by `DN_STEP` (default 18) each cycle, with a floor at 0, while it is above `RESTART_LVL` (default 72). Once it is at or below that threshold, the fault latch clears on the next cycle and charging resumes with `out_en` 1. `ovc` is ignored while the latch is set.
- R6: `duty_lim` equals the smaller of `duty_req` and `ss_level` when `out_en` is 1, and 0 otherwise.
- R7: The supply monitor becomes good when `supply` is at or above `START_TH` (default 160). It becomes bad when `supply` is below `STOP_TH` (default 100). Values between the two thresholds keep the previous verdict.
- R8: One cycle after the monitor reports bad, the block is locked out: `out_en` is 0, `ss_level` is 0 and any fault is cleared, whatever the previous phase. After the monitor reports good, charging starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply | input | SUP_W | Sampled supply level code |
| ovc | input | 1 | Overcurrent flag, active high |
| duty_req | input | LVL_W | Duty word requested by the control loop |
| out_en | output | 1 | Enable for the PWM outputs |
| ss_level | output | LVL_W | Current soft-start level |
| duty_lim | output | LVL_W | Duty limit passed to the PWM generator |

## Verification
The hardest situation to reach is a fault raised partway up a charge ramp, followed by more overcurrent pulses during the forced climb and the discharge, and possibly a supply dip in the middle. Reaching it needs hundreds of quiet cycles first. The stimulus keeps the overcurrent probability low so that ramps complete, then injects pulses in bursts and holds the supply in the hysteresis band or below the stop threshold for short random stretches. A cycle-accurate bench model compares the outputs every cycle, and each comparison is tagged by the model's phase.

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq #(
  parameter int LVL_W       = 10,
  parameter int SUP_W       = 8,
  parameter int FULL_LVL    = 720,
  parameter int RESTART_LVL = 72,
  parameter int UP_STEP     = 1,
  parameter int DN_STEP     = 18,
  parameter int START_TH    = 160,
  parameter int STOP_TH     = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUP_W-1:0] supply,
  input  logic             ovc,
  input  logic [LVL_W-1:0] duty_req,
  output logic             out_en,
  output logic [LVL_W-1:0] ss_level,
  output logic [LVL_W-1:0] duty_lim
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(FULL_LVL);
  localparam logic [LVL_W-1:0] RST  = LVL_W'(RESTART_LVL);
  localparam logic [LVL_W:0]   UPW  = (LVL_W+1)'(UP_STEP);
  localparam logic [LVL_W-1:0] DNW  = LVL_W'(DN_STEP);

  typedef enum logic [2:0] {
    S_LOCK, S_CHG, S_RUN, S_WAIT_FULL, S_DISCH
  } st_t;

  st_t st, st_nx;
  logic uv_ok;
  logic [LVL_W-1:0] lvl, lvl_nx, lvl_up, lvl_dn;
  logic [LVL_W:0] sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) uv_ok <= 1'b0;
    else if (!uv_ok && supply >= SUP_W'(START_TH)) uv_ok <= 1'b1;
    else if (uv_ok && supply < SUP_W'(STOP_TH)) uv_ok <= 1'b0;

  assign sum    = {1'b0, lvl} + UPW;
  assign lvl_up = (sum >= {1'b0, FULL}) ? FULL : sum[LVL_W-1:0];
  assign lvl_dn = (lvl > DNW) ? lvl - DNW : '0;

  always_comb begin
    st_nx  = st;
    lvl_nx = lvl;
    if (!uv_ok) begin
      st_nx  = S_LOCK;
      lvl_nx = '0;
    end else begin
      case (st)
        S_LOCK: begin
          st_nx  = S_CHG;
          lvl_nx = '0;
        end
        S_CHG: begin
          lvl_nx = lvl_up;
          if (ovc) st_nx = S_WAIT_FULL;
          else if (lvl_up == FULL) st_nx = S_RUN;
        end
        S_RUN:
          if (ovc) st_nx = S_DISCH;
        S_WAIT_FULL:
          if (lvl == FULL) st_nx = S_DISCH;
          else lvl_nx = lvl_up;
        S_DISCH:
          if (lvl <= RST) st_nx = S_CHG;
          else lvl_nx = lvl_dn;
        default: begin
          st_nx  = S_LOCK;
          lvl_nx = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_LOCK;
      lvl <= '0;
    end else begin
      st  <= st_nx;
      lvl <= lvl_nx;
    end

  assign out_en   = (st == S_CHG) || (st == S_RUN);
  assign ss_level = lvl;
  assign duty_lim = !out_en ? '0 : (duty_req < lvl) ? duty_req : lvl;

  always_comb begin
    AST_LVL_CAP: assert (!rst_n || lvl <= FULL); // R2
    AST_DUTY_CAP: assert (!rst_n || (duty_lim <= lvl && duty_lim <= duty_req)); // R6
  end

  AST_OC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && ovc && uv_ok) |=> !out_en); // R3
  AST_WAIT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT_FULL && lvl != FULL && uv_ok) |=> (lvl > $past(lvl) && !out_en)); // R4
  AST_DISCH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DISCH && lvl > RST && uv_ok) |=> (lvl < $past(lvl) && !out_en)); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok |=> (!out_en && lvl == '0)); // R8

endmodule

// File: tb/sim_softstart_fault_seq.sv
module sim_softstart_fault_seq;
  localparam int LW = 10;
  localparam int FULL = 720, RSTL = 72, UP = 1, DN = 18, STA = 160, STO = 100;
  localparam int M_LOCK = 0, M_CHG = 1, M_RUN = 2, M_WAIT = 3, M_DIS = 4;

  logic clk = 0, rst_n = 0, ovc = 0;
  logic [7:0] supply = 0;
  logic [LW-1:0] duty_req = 0;
  logic out_en;
  logic [LW-1:0] ss_level, duty_lim;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_st = M_LOCK, m_lvl = 0;
  bit m_ok = 0;

  always #2.5 clk = ~clk;

  softstart_fault_seq u0 (.clk(clk), .rst_n(rst_n), .supply(supply), .ovc(ovc),
    .duty_req(duty_req), .out_en(out_en), .ss_level(ss_level), .duty_lim(duty_lim));

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      M_LOCK: return "R8";
      M_CHG:  return "R2";
      M_RUN:  return "R3";
      M_WAIT: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tg, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tg, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int ns, nl;
    bit nok;
    cyc++;
    if (!rst_n) begin
      m_st = M_LOCK; m_lvl = 0; m_ok = 0;
    end else begin
      ns = m_st; nl = m_lvl;
      nok = m_ok;
      if (!m_ok && supply >= STA) nok = 1;
      else if (m_ok && supply < STO) nok = 0;
      if (!m_ok) begin ns = M_LOCK; nl = 0; end
      else case (m_st)
        M_LOCK: begin ns = M_CHG; nl = 0; end
        M_CHG: begin
          nl = min2(m_lvl + UP, FULL);
          if (ovc) ns = M_WAIT; else if (nl == FULL) ns = M_RUN;
        end
        M_RUN: if (ovc) ns = M_DIS;
        M_WAIT: if (m_lvl == FULL) ns = M_DIS; else nl = min2(m_lvl + UP, FULL);
        default: if (m_lvl <= RSTL) ns = M_CHG; else nl = (m_lvl > DN) ? m_lvl - DN : 0;
      endcase
      m_st = ns; m_lvl = nl; m_ok = nok;
    end
  end

  task automatic compare_all();
    int een, edl;
    een = (m_st == M_CHG || m_st == M_RUN) ? 1 : 0;
    edl = een ? min2(int'(duty_req), m_lvl) : 0;
    chk(tag_of(m_st), "out_en", int'(out_en), een);
    chk(tag_of(m_st), "ss_level", int'(ss_level), m_lvl);
    chk("R6", "duty_lim", int'(duty_lim), edl);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    #200000000;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    duty_req = 10'd500;
    supply = 8'd130;
    repeat (3) @(negedge clk);
    chk("R1", "out_en", int'(out_en), 0);
    chk("R1", "ss_level", int'(ss_level), 0);
    chk("R1", "duty_lim", int'(duty_lim), 0);
    rst_n = 1;
    step(10);
    chk("R7", "out_en in band from lockout", int'(out_en), 0);
    supply = 8'd160;
    step(3);
    chk("R7", "out_en at start threshold", int'(out_en), 1);
    supply = 8'd100;
    step(20);
    chk("R7", "out_en held in band", int'(out_en), 1);
    chk("R2", "level after ramp start", int'(ss_level), 21);
    step(760);
    chk("R3", "run at full", int'(ss_level), FULL);
    chk("R6", "duty capped by request", int'(duty_lim), 500);
    ovc = 1; step(1); ovc = 0;
    chk("R3", "disabled after ovc", int'(out_en), 0);
    step(60);
    chk("R5", "restarted after discharge", int'(out_en), 1);
    step(100);
    ovc = 1; step(1); ovc = 0;
    chk("R4", "disabled mid-ramp", int'(out_en), 0);
    step(5);
    chk("R4", "level still rising", int'(ss_level) > 180 ? 1 : 0, 1);
    step(700);
    supply = 8'd99;
    step(2);
    chk("R7", "stop threshold", int'(out_en), 0);
    step(1);
    chk("R8", "level cleared", int'(ss_level), 0);
    supply = 8'd200;
    for (int i = 0; i < 40000; i++) begin
      int r;
      @(negedge clk);
      compare_all();
      r = int'($urandom_range(0, 999));
      ovc = (r < 2) || (r >= 990 && r < 994);
      if ($urandom_range(0, 15) == 0) duty_req = LW'($urandom_range(0, 1023));
      r = int'($urandom_range(0, 4999));
      if (r < 3) supply = 8'($urandom_range(0, 99));
      else if (r < 8) supply = 8'($urandom_range(100, 159));
      else if (r < 20) supply = 8'($urandom_range(160, 255));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule